// File: doc/BRIEF.md
# Pair-Transition Flag Machine

This block watches a two-bit input pair, sampled on every rising clock edge, and keeps a single output flag. The flag is not a pattern-match strobe: it is a held bit. Specific ordered pairs of consecutive samples set it, clear it or invert it. Every other pair of consecutive samples leaves it as it was.

The machine is of the Moore type. Its state is the class of the previously sampled pair together with the current flag value. The flag is read straight from the state register, so it changes only at a clock edge and never follows the inputs combinationally. The pair `{in_a, in_b}` uses `in_a` as the left (more significant) bit. The pairs 00 and 11 fall into one shared class. The pairs 01 and 10 each have a class of their own.

A synchronous active-high reset puts the machine in a known starting state. The block suits control paths where a two-wire code steers a sticky mode bit.

Top module: `pair_toggle_fsm`

## Requirements
- R1: After a clock edge with `rst` high, `flag_o` is 0 and the remembered previous pair behaves as if it had been 00.
- R2: A sample of 10 followed at the next edge by 11 makes `flag_o` 1 after that second edge.
- R3: A sample of 01 followed at the next edge by 11 makes `flag_o` 0 after that second edge.
- R4: A sample of 10 followed at the next edge by 01 inverts `flag_o` at that second edge.
- R5: Any other ordered pair of consecutive samples leaves `flag_o` unchanged at the second edge.
- R6: The pairs 00 and 11 are one previous-pair class: a 10 or 01 that comes after 00 or after 11 affects the flag in exactly the same way. For example, 10, 00, 11 does not set the flag, and 01, 00, 11 does not clear it.
- R7: `flag_o` depends on the state alone. Input changes between clock edges do not reach the output until the next rising edge.
- R8: Reset takes priority. An edge with `rst` high gives `flag_o` = 0 even when the inputs would otherwise set or invert the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | Left (more significant) bit of the sampled pair |
| in_b | input | 1 | Right (less significant) bit of the sampled pair |
| flag_o | output | 1 | Held output flag, driven from the state register |

## Verification
On every cycle, the embedded properties check the set, clear and invert rules, the hold rule for all other pairs, the tracking of the previous-pair class and the reset value. Each of these is checked against the previous class held in the state register and the pair currently sampled. Only the bench scenarios can show the rest. These are the merging of 00 and 11 in longer histories, the immunity of the output to input changes between edges, and the agreement with an independent last-pair model over a long pseudo-random stream.

// File: rtl/pair_toggle_pkg.sv
package pair_toggle_pkg;

    localparam int PAIR_W = 2;
    localparam int CLS_W  = 2;

    // Class of the previously sampled pair; the spare code is never entered
    typedef enum logic [CLS_W-1:0] {
        CLS_SAME  = 2'b00,   // 00 or 11
        CLS_LO_HI = 2'b01,   // 01
        CLS_HI_LO = 2'b10,   // 10
        CLS_SPARE = 2'b11
    } pair_cls_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'b00,
        ACT_CLEAR = 2'b01,
        ACT_SET   = 2'b10,
        ACT_FLIP  = 2'b11
    } flag_act_e;

    typedef struct packed {
        pair_cls_e cls;
        logic      flag;
    } ptm_state_t;

    localparam ptm_state_t PTM_RESET = '{cls: CLS_SAME, flag: 1'b0};

    function automatic pair_cls_e classify(input logic [PAIR_W-1:0] p);
        case (p)
            2'b01:   return CLS_LO_HI;
            2'b10:   return CLS_HI_LO;
            default: return CLS_SAME;
        endcase
    endfunction

    function automatic logic apply_act(input flag_act_e a, input logic f);
        case (a)
            ACT_CLEAR: return 1'b0;
            ACT_SET:   return 1'b1;
            ACT_FLIP:  return ~f;
            default:   return f;
        endcase
    endfunction

endpackage

// File: rtl/ptm_classify.sv
module ptm_classify
    import pair_toggle_pkg::*;
(
    input  logic [PAIR_W-1:0] pair_i,
    output pair_cls_e         cls_o
);

    always_comb begin
        cls_o = classify(pair_i);
    end

endmodule

// File: rtl/ptm_action.sv
module ptm_action
    import pair_toggle_pkg::*;
(
    input  pair_cls_e         prev_cls_i,
    input  logic [PAIR_W-1:0] pair_i,
    output flag_act_e         act_o
);

    always_comb begin
        act_o = ACT_HOLD;
        unique case (prev_cls_i)
            CLS_HI_LO: begin
                if (pair_i == 2'b11)      act_o = ACT_SET;
                else if (pair_i == 2'b01) act_o = ACT_FLIP;
            end
            CLS_LO_HI: begin
                if (pair_i == 2'b11)      act_o = ACT_CLEAR;
            end
            default: act_o = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/ptm_state_reg.sv
module ptm_state_reg
    import pair_toggle_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pair_cls_e next_cls_i,
    input  flag_act_e act_i,
    output pair_cls_e cls_o,
    output logic      flag_o
);

    ptm_state_t state_q;
    ptm_state_t state_d;

    always_comb begin
        state_d.cls  = next_cls_i;
        state_d.flag = apply_act(act_i, state_q.flag);
        // Spare class code recovers to the reset state
        if (state_q.cls == CLS_SPARE) state_d = PTM_RESET;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PTM_RESET;
        else     state_q <= state_d;
    end

    assign cls_o  = state_q.cls;
    assign flag_o = state_q.flag;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_q == PTM_RESET));

endmodule

// File: rtl/pair_toggle_fsm.sv
module pair_toggle_fsm
    import pair_toggle_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_a,
    input  logic in_b,
    output logic flag_o
);

    logic [PAIR_W-1:0] pair;
    pair_cls_e         cur_cls;
    pair_cls_e         prev_cls;
    flag_act_e         act;

    assign pair = {in_a, in_b};

    ptm_classify u_classify (
        .pair_i (pair),
        .cls_o  (cur_cls)
    );

    ptm_action u_action (
        .prev_cls_i (prev_cls),
        .pair_i     (pair),
        .act_o      (act)
    );

    ptm_state_reg u_state (
        .clk        (clk),
        .rst        (rst),
        .next_cls_i (cur_cls),
        .act_i      (act),
        .cls_o      (prev_cls),
        .flag_o     (flag_o)
    );

    // R1 / R8
    reset_flag_chk: assert property (@(posedge clk)
        rst |=> !flag_o);

    // R2
    set_after_hilo_chk: assert property (@(posedge clk) disable iff (rst)
        (prev_cls == CLS_HI_LO && pair == 2'b11) |=> flag_o);

    // R3
    clear_after_lohi_chk: assert property (@(posedge clk) disable iff (rst)
        (prev_cls == CLS_LO_HI && pair == 2'b11) |=> !flag_o);

    // R4
    flip_chk: assert property (@(posedge clk) disable iff (rst)
        (prev_cls == CLS_HI_LO && pair == 2'b01) |=> (flag_o != $past(flag_o)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !((prev_cls == CLS_HI_LO && (pair == 2'b11 || pair == 2'b01)) ||
          (prev_cls == CLS_LO_HI && pair == 2'b11)) |=> $stable(flag_o));

    // R6
    same_class_chk: assert property (@(posedge clk) disable iff (rst)
        (pair == 2'b00 || pair == 2'b11) |=> (prev_cls == CLS_SAME));

endmodule

// File: tb/test_pair_toggle_fsm.sv
module test_pair_toggle_fsm;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_a = 1'b0;
    logic in_b = 1'b0;
    logic flag;

    int checks = 0;
    int fails  = 0;
    logic       m_flag = 1'b0;
    logic [1:0] m_prev = 2'b00;
    logic [7:0] lfsr   = 8'hA5;

    always #5 clk = ~clk;

    pair_toggle_fsm i_pair_toggle_fsm (
        .clk    (clk),
        .rst    (rst),
        .in_a   (in_a),
        .in_b   (in_b),
        .flag_o (flag)
    );

    task automatic check(input string req, input logic exp);
        checks++;
        if (flag !== exp) begin
            fails++;
            $display("FAIL %s: flag_o=%b expected %b at %0t", req, flag, exp, $time);
        end
    endtask

    // Reference: remember last pair, apply the rules
    task automatic model_step(input logic [1:0] p);
        logic [1:0] pc;
        logic [1:0] cc;
        pc = (m_prev == 2'b11) ? 2'b00 : m_prev;
        cc = p;
        if (pc == 2'b10 && cc == 2'b11)      m_flag = 1'b1;
        else if (pc == 2'b01 && cc == 2'b11) m_flag = 1'b0;
        else if (pc == 2'b10 && cc == 2'b01) m_flag = ~m_flag;
        m_prev = p;
    endtask

    task automatic step(input logic [1:0] p, input string req);
        @(negedge clk);
        {in_a, in_b} = p;
        @(posedge clk);
        model_step(p);
        #1;
        check(req, m_flag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {in_a, in_b} = 2'b10;
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R1", 1'b0);
        @(negedge clk);
        rst = 1'b0;
        {in_a, in_b} = 2'b00;
        m_flag = 1'b0;
        m_prev = 2'b00;
    endtask

    task automatic t_set();
        do_reset();
        step(2'b10, "R5");
        step(2'b11, "R2");
        check("R2", 1'b1);
        step(2'b11, "R5");
        check("R5", 1'b1);
    endtask

    task automatic t_clear();
        do_reset();
        step(2'b10, "R2");
        step(2'b11, "R2");
        step(2'b01, "R5");
        check("R5", 1'b1);
        step(2'b11, "R3");
        check("R3", 1'b0);
    endtask

    task automatic t_toggle();
        do_reset();
        step(2'b10, "R4");
        step(2'b01, "R4");
        check("R4", 1'b1);
        step(2'b10, "R5");
        check("R5", 1'b1);
        step(2'b01, "R4");
        check("R4", 1'b0);
    endtask

    task automatic t_hold();
        do_reset();
        step(2'b10, "R2");
        step(2'b11, "R2");
        step(2'b00, "R5");
        step(2'b01, "R5");
        step(2'b01, "R5");
        step(2'b10, "R5");
        step(2'b10, "R5");
        step(2'b00, "R5");
        step(2'b11, "R5");
        check("R5", 1'b1);
    endtask

    task automatic t_same_class();
        do_reset();
        step(2'b10, "R6");
        step(2'b00, "R6");
        step(2'b11, "R6");
        check("R6", 1'b0);
        step(2'b10, "R6");
        step(2'b11, "R6");
        step(2'b01, "R6");
        step(2'b00, "R6");
        step(2'b11, "R6");
        check("R6", 1'b1);
        step(2'b01, "R6");
        step(2'b11, "R6");
        check("R6", 1'b0);
    endtask

    task automatic t_between_edges();
        do_reset();
        @(negedge clk);
        {in_a, in_b} = 2'b10;
        @(posedge clk);
        model_step(2'b10);
        #2;
        {in_a, in_b} = 2'b11;
        #1;
        check("R7", 1'b0);
        @(posedge clk);
        model_step(2'b11);
        #1;
        check("R7", 1'b1);
        {in_a, in_b} = 2'b01;
        #2;
        check("R7", 1'b1);
        {in_a, in_b} = 2'b00;
        @(posedge clk);
        model_step(2'b00);
        #1;
        check("R7", m_flag);
    endtask

    task automatic t_reset_priority();
        do_reset();
        step(2'b10, "R8");
        step(2'b11, "R8");
        step(2'b10, "R8");
        check("R8", 1'b1);
        @(negedge clk);
        rst = 1'b1;
        {in_a, in_b} = 2'b01;
        @(posedge clk);
        #1;
        check("R8", 1'b0);
        @(negedge clk);
        rst = 1'b0;
        {in_a, in_b} = 2'b00;
        m_flag = 1'b0;
        m_prev = 2'b00;
        step(2'b11, "R8");
        check("R8", 1'b0);
    endtask

    task automatic t_stream();
        do_reset();
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[1:0], "R2/R3/R4/R5");
        end
    endtask

    initial begin
        t_set();
        t_clear();
        t_toggle();
        t_hold();
        t_same_class();
        t_between_edges();
        t_reset_priority();
        t_stream();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: run not finished, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule